// File: doc/BRIEF.md
# Cascadable Gated Dual Timer

The block holds two 16-bit up-counters. Software sets their behaviour through one configuration byte and a few more registers on a simple synchronous register bus. Each counter has three controls. A hold bit keeps it cleared. A freeze bit halts it while every register stays reachable on the bus. It also has a programmable reference value: when the count reaches the reference, the counter returns to zero and raises a one-cycle event.

An external active-low gate input passes through a synchronizer. It can pause and resume any counter that has gating enabled. A mode bit selects whether the gate's opening edge clears the count first or resumes from the held value. A cascade bit joins the two counters into one 32-bit counter, `{count2, count1}`, which is compared against `{ref2, ref1}`.

Top module: `dual_gated_timer`

## Requirements
- R1: Bus address 0 holds the configuration byte, which resets to 0x00. Its bits, from bit 7 down to bit 0, are: cascade, reserved, freeze2, run2, gate-restore, reserved, freeze1, run1. Bits 6 and 2 and every bit above bit 7 always read 0, so writing 0xFF reads back 0xBB.
- R2: While a counter's run bit is 0, its count is 0 from the next cycle on. While the run bit is 1 and the freeze bit is 0, the counter advances by one per cycle.
- R3: While a counter's run bit and freeze bit are both 1, its count does not change. The reference registers (address 1 for counter 1, address 2 for counter 2) stay writable and read back what was written.
- R4: Outside cascade mode, a counter whose count equals its reference goes to 0 on the next edge. Its match output is 1 for exactly that one following cycle. With reference 5 the counter pulses once every 6 cycles.
- R5: Address 3 bit 0 enables gating for counter 1 and bit 1 enables it for counter 2. Gating starts open. A rising edge on gateN closes the gate and a falling edge opens it. The edge takes effect after a two-flop synchronizer, so a gated counter stops a few cycles after gateN rises.
- R6: When the gate-restore bit is 0, a falling gate edge clears each active counter that has gating enabled.
- R7: When the gate-restore bit is 1, a falling gate edge resumes counting from the held value without clearing it.
- R8: When the cascade bit is 1, counter 1 runs under its own run, freeze and gate controls and wraps only from 0xFFFF to 0. Counter 2 advances only on the cycle in which counter 1 wraps.
- R9: In cascade mode, when `{count2, count1}` equals `{ref2, ref1}`, both counters go to 0 and match2 pulses for one cycle. match1 stays 0.
- R10: A counter whose gating bit is 0 ignores gateN and keeps counting while the gate is closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gateN | input | 1 | Active-low external gate, asynchronous |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address (0 config, 1 ref1, 2 ref2, 3 gate enables, 4 count1, 5 count2) |
| busWdata | input | 16 | Register write data |
| busRdata | output | 16 | Combinational read data for busAddr |
| count1 | output | 16 | Counter 1 value |
| count2 | output | 16 | Counter 2 value |
| match1 | output | 1 | Counter 1 reference event |
| match2 | output | 1 | Counter 2 event, or the 32-bit event in cascade mode |

## Verification
The bench targets several corner cases, each with a visible failure:
- Reserved configuration bits. A design that stored them would read back 0xFF instead of 0xBB.
- Freezing a counter while its reference is rewritten. A design that let freeze also block bus writes would return the stale reference.
- The two gate-restore modes. Swapping them either clears a held count or fails to restart it.
- Gating on one counter only. A shared gate would stall the ungated counter.
- A full 65,536-cycle cascade run to a 32-bit reference. A wrong carry would advance counter 2 early or never, and a 16-bit compare would fire match1 or match2 too soon.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  // configuration byte bit positions (timer i uses run at 4*i, freeze at 4*i+1)
  localparam int CFG_CASCADE = 7;
  localparam int CFG_GATEMODE = 3;
  localparam logic [7:0] CFG_MASK = 8'hBB;

  localparam logic [2:0] ADDR_CFG = 3'd0;
  localparam logic [2:0] ADDR_REF1 = 3'd1;
  localparam logic [2:0] ADDR_REF2 = 3'd2;
  localparam logic [2:0] ADDR_GATEEN = 3'd3;
  localparam logic [2:0] ADDR_CNT1 = 3'd4;
  localparam logic [2:0] ADDR_CNT2 = 3'd5;

  typedef struct packed {
    logic cascade;
    logic clr1;
    logic inc1;
    logic clr2;
    logic inc2;
  } tmrStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import dual_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateN,
  input  logic             busWe,
  input  logic [2:0]       busAddr,
  input  logic [CNT_W-1:0] busWdata,
  input  logic [CNT_W-1:0] cnt1,
  input  logic [CNT_W-1:0] cnt2,
  output logic [CNT_W-1:0] busRdata,
  output logic [CNT_W-1:0] ref1,
  output logic [CNT_W-1:0] ref2,
  output logic [7:0]       cfgByte,
  output tmrStrobe_t       strobe
);
  localparam int PAD_W = CNT_W - 8;

  logic [7:0] cfgQ;
  logic [CNT_W-1:0] ref1Q, ref2Q;
  logic [1:0] gateEnQ;
  logic [SYNC_STAGES-1:0] syncQ;
  logic gatePrev, gateOpen, gateRise, gateFall;
  logic [1:0] active, runT, restartT, holdT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      ref1Q <= '0;
      ref2Q <= '0;
      gateEnQ <= '0;
    end else if (busWe) begin
      case (busAddr)
        ADDR_CFG:    cfgQ <= busWdata[7:0] & CFG_MASK;
        ADDR_REF1:   ref1Q <= busWdata;
        ADDR_REF2:   ref2Q <= busWdata;
        ADDR_GATEEN: gateEnQ <= busWdata[1:0];
        default: ;
      endcase
    end
  end

  // gate synchronizer and edge tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      gatePrev <= 1'b0;
      gateOpen <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], gateN};
      gatePrev <= syncQ[SYNC_STAGES-1];
      if (gateRise) gateOpen <= 1'b0;
      else if (gateFall) gateOpen <= 1'b1;
    end
  end

  assign gateRise = syncQ[SYNC_STAGES-1] & ~gatePrev;
  assign gateFall = ~syncQ[SYNC_STAGES-1] & gatePrev;

  for (genvar i = 0; i < 2; i++) begin : g_tmr
    assign holdT[i] = ~cfgQ[4*i];
    assign active[i] = cfgQ[4*i] & ~cfgQ[4*i+1];
    assign runT[i] = active[i] & (~gateEnQ[i] | gateOpen);
    assign restartT[i] = gateFall & gateEnQ[i] & ~cfgQ[CFG_GATEMODE] & active[i];
  end

  always_comb begin
    strobe.cascade = cfgQ[CFG_CASCADE];
    strobe.clr1 = holdT[0] | restartT[0];
    strobe.inc1 = runT[0];
    strobe.clr2 = holdT[1] | (cfgQ[CFG_CASCADE] ? restartT[0] : restartT[1]);
    strobe.inc2 = cfgQ[CFG_CASCADE] ? runT[0] : runT[1];
  end

  always_comb begin
    case (busAddr)
      ADDR_CFG:    busRdata = {{PAD_W{1'b0}}, cfgQ};
      ADDR_REF1:   busRdata = ref1Q;
      ADDR_REF2:   busRdata = ref2Q;
      ADDR_GATEEN: busRdata = {{(CNT_W-2){1'b0}}, gateEnQ};
      ADDR_CNT1:   busRdata = cnt1;
      ADDR_CNT2:   busRdata = cnt2;
      default:     busRdata = '0;
    endcase
  end

  assign ref1 = ref1Q;
  assign ref2 = ref2Q;
  assign cfgByte = cfgQ;
endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import dual_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] ref1,
  input  logic [CNT_W-1:0] ref2,
  output logic [CNT_W-1:0] cnt1,
  output logic [CNT_W-1:0] cnt2,
  output logic             match1,
  output logic             match2
);
  logic hit1, hit2, hitWide, wrap1;

  assign hit1 = (cnt1 == ref1);
  assign hit2 = (cnt2 == ref2);
  assign hitWide = ({cnt2, cnt1} == {ref2, ref1});
  assign wrap1 = &cnt1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt1 <= '0;
      cnt2 <= '0;
      match1 <= 1'b0;
      match2 <= 1'b0;
    end else begin
      if (strobe.clr1) cnt1 <= '0;
      else if (strobe.inc1) begin
        if (strobe.cascade ? hitWide : hit1) cnt1 <= '0;
        else cnt1 <= cnt1 + 1'b1;
      end

      if (strobe.clr2) cnt2 <= '0;
      else if (strobe.inc2) begin
        if (strobe.cascade) begin
          if (hitWide) cnt2 <= '0;
          else if (wrap1) cnt2 <= cnt2 + 1'b1;
        end else if (hit2) cnt2 <= '0;
        else cnt2 <= cnt2 + 1'b1;
      end

      match1 <= ~strobe.cascade & ~strobe.clr1 & strobe.inc1 & hit1;
      match2 <= strobe.cascade ? (~strobe.clr1 & strobe.inc1 & hitWide)
                               : (~strobe.clr2 & strobe.inc2 & hit2);
    end
  end
endmodule

// File: rtl/dual_gated_timer.sv
module dual_gated_timer
  import dual_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateN,
  input  logic             busWe,
  input  logic [2:0]       busAddr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  output logic [CNT_W-1:0] count1,
  output logic [CNT_W-1:0] count2,
  output logic             match1,
  output logic             match2
);
  tmrStrobe_t strobe;
  logic [CNT_W-1:0] ref1, ref2;
  logic [7:0] cfgByte;

  timer_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .gateN(gateN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .cnt1(count1), .cnt2(count2), .busRdata(busRdata),
    .ref1(ref1), .ref2(ref2), .cfgByte(cfgByte), .strobe(strobe)
  );

  timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ref1(ref1), .ref2(ref2),
    .cnt1(count1), .cnt2(count2), .match1(match1), .match2(match2)
  );
endmodule

// File: rtl/dual_gated_timer_chk.sv
module dual_gated_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       busAddr,
  input logic [CNT_W-1:0] busRdata,
  input logic [7:0]       cfgByte,
  input logic [CNT_W-1:0] count1,
  input logic [CNT_W-1:0] count2,
  input logic             match1,
  input logic             match2
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 3'd0) |-> (busRdata[6] == 1'b0 && busRdata[2] == 1'b0 && busRdata[CNT_W-1:8] == '0));

  // R2
  held_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgByte[0] |=> (count1 == '0));

  // R3
  freeze_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgByte[1] && cfgByte[0]) |=> $stable(count1));

  // R4
  match1_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    match1 |-> (count1 == '0));

  // R9
  match2_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    match2 |-> (count2 == '0));

  // R8
  carry_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgByte[7] && cfgByte[4]) |=> (count2 == $past(count2) || count1 == '0));
endmodule

bind dual_gated_timer dual_gated_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdata(busRdata), .cfgByte(cfgByte),
  .count1(count1), .count2(count2), .match1(match1), .match2(match2)
);

// File: tb/dual_gated_timer_bench.sv
module dual_gated_timer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateN = 1'b0;
  logic busWe = 1'b0;
  logic [2:0] busAddr = 3'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata, count1, count2;
  logic match1, match2;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  dual_gated_timer u_dual_gated_timer (
    .clk(clk), .rstN(rstN), .gateN(gateN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .count1(count1), .count2(count2),
    .match1(match1), .match2(match2)
  );

  // behavioural reference model
  int mc1, mc2, mr1, mr2;
  bit mm1, mm2, g1, g2, g3, mopen;
  bit [7:0] mcfg;
  bit [1:0] mge;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mc1 = 0; mc2 = 0; mr1 = 0; mr2 = 0; mm1 = 0; mm2 = 0;
      g1 = 0; g2 = 0; g3 = 0; mopen = 1; mcfg = 0; mge = 0;
    end else begin
      bit rise, fall, a1, a2, r1, r2, s1, s2, c1clr, c2clr;
      int n1, n2;
      longint v, rv;
      rise = g2 && !g3;
      fall = !g2 && g3;
      a1 = mcfg[0] && !mcfg[1];
      a2 = mcfg[4] && !mcfg[5];
      r1 = a1 && (!mge[0] || mopen);
      r2 = a2 && (!mge[1] || mopen);
      s1 = fall && mge[0] && !mcfg[3] && a1;
      s2 = fall && mge[1] && !mcfg[3] && a2;
      n1 = mc1; n2 = mc2;
      c1clr = !mcfg[0] || s1;
      if (mcfg[7]) begin
        v = longint'(mc2) * 65536 + mc1;
        rv = longint'(mr2) * 65536 + mr1;
        c2clr = !mcfg[4] || s1;
        if (c1clr) n1 = 0;
        else if (r1) n1 = (v == rv) ? 0 : (mc1 + 1) % 65536;
        if (c2clr) n2 = 0;
        else if (r1 && v == rv) n2 = 0;
        else if (r1 && mc1 == 65535) n2 = (mc2 + 1) % 65536;
        mm1 = 0;
        mm2 = !c1clr && r1 && (v == rv);
      end else begin
        c2clr = !mcfg[4] || s2;
        if (c1clr) n1 = 0; else if (r1) n1 = (mc1 == mr1) ? 0 : mc1 + 1;
        if (c2clr) n2 = 0; else if (r2) n2 = (mc2 == mr2) ? 0 : mc2 + 1;
        mm1 = !c1clr && r1 && (mc1 == mr1);
        mm2 = !c2clr && r2 && (mc2 == mr2);
      end
      mc1 = n1; mc2 = n2;
      if (rise) mopen = 0; else if (fall) mopen = 1;
      g3 = g2; g2 = g1; g1 = gateN;
      if (busWe) begin
        case (busAddr)
          3'd0: mcfg = busWdata[7:0] & 8'hBB;
          3'd1: mr1 = busWdata;
          3'd2: mr2 = busWdata;
          3'd3: mge = busWdata[1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic int modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mcfg;
      3'd1: return mr1;
      3'd2: return mr2;
      3'd3: return mge;
      3'd4: return mc1;
      3'd5: return mc2;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      check({phase, " count1"}, count1, mc1);
      check({phase, " count2"}, count2, mc2);
      check({phase, " match1"}, match1, mm1);
      check({phase, " match2"}, match2, mm2);
      check({phase, " rdata"}, busRdata, modelRead(busAddr));
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    tick(1);
    busWe = 1'b0;
  endtask

  task automatic readAt(input logic [2:0] a, output int v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cycles < 200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 200000);
    finishRun();
  end

  initial begin
    int v, held, pulses, sawCarry;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1: reset state and reserved bits
    readAt(3'd0, v); check("R1 cfg reset", v, 0);
    check("R1 count1 reset", count1, 0);
    check("R1 count2 reset", count2, 0);
    busWrite(3'd0, 16'hFFFF);
    readAt(3'd0, v); check("R1 cfg readback", v, 8'hBB);
    busWrite(3'd0, 16'h0000);

    // R2: held while run bit is 0
    phase = "R2";
    busWrite(3'd1, 16'd5);
    busWrite(3'd2, 16'd7);
    tick(10);
    check("R2 count1 held", count1, 0);
    busWrite(3'd0, 16'h0011);
    tick(4);
    check("R2 count1 advancing", count1, 4);

    // R4: match period with reference 5
    phase = "R4";
    pulses = 0;
    for (int i = 0; i < 60; i++) begin
      tick(1);
      if (match1) pulses++;
    end
    check("R4 match1 pulses in 60 cycles", pulses, 10);

    // R3: freeze keeps count, bus stays usable
    phase = "R3";
    busWrite(3'd0, 16'h0013);
    tick(1);
    held = count1;
    busWrite(3'd1, 16'd9);
    tick(8);
    check("R3 frozen count1", count1, held);
    readAt(3'd1, v); check("R3 ref1 readback while frozen", v, 9);
    busWrite(3'd1, 16'd1000);
    busWrite(3'd0, 16'h0011);
    tick(20);

    // R5/R10: gate closes timer 1 only
    phase = "R5";
    busWrite(3'd3, 16'h0001);
    busWrite(3'd0, 16'h0019);
    gateN = 1'b1;
    tick(6);
    held = count1;
    pulses = 0;
    for (int i = 0; i < 16; i++) begin
      tick(1);
      if (match2) pulses++;
    end
    check("R5 gated count1 stable", count1, held);
    phase = "R10";
    check("R10 ungated timer2 still matching", pulses, 2);

    // R7: normal mode resumes from held value
    phase = "R7";
    gateN = 1'b0;
    tick(8);
    check("R7 resumed without clear", (count1 > held) ? 1 : 0, 1);

    // R6: restart mode clears on falling edge
    phase = "R6";
    busWrite(3'd0, 16'h0011);
    gateN = 1'b1;
    tick(8);
    gateN = 1'b0;
    sawCarry = 0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (count1 == 0) sawCarry = 1;
    end
    check("R6 count1 cleared by gate", sawCarry, 1);

    // R8/R9: cascade to 32-bit reference {1,2}
    phase = "R8";
    busWrite(3'd3, 16'h0000);
    busWrite(3'd0, 16'h0000);
    busWrite(3'd1, 16'd2);
    busWrite(3'd2, 16'd1);
    busWrite(3'd0, 16'h0091);
    pulses = 0; held = 0; sawCarry = 0;
    for (int i = 0; i < 65545; i++) begin
      tick(1);
      if (match2) pulses++;
      if (match1) held++;
      if (count2 == 1 && count1 == 0) sawCarry = 1;
    end
    check("R8 carry into count2 seen", sawCarry, 1);
    phase = "R9";
    check("R9 single wide match", pulses, 1);
    check("R9 no match1 in cascade", held, 0);
    tick(2);
    finishRun();
  end
endmodule